// File: doc/BRIEF.md
# UART Register Front End with Divisor-Latch Aliasing

This block is the memory-mapped register layer of a 16550-style serial port. A simple synchronous bus presents a byte offset, a read strobe, a write strobe, 16-bit write data and a width flag. The block returns registered 16-bit read data and a one-cycle error pulse. Registers are 16 bits wide and sit on a 4-byte stride. Bit 7 of the line-control register redirects the first two slots from the data and interrupt-enable registers to the two halves of the baud divisor.

On the serial side, the block passes each transmitted byte to a serializer through a valid/ready handshake. It takes received bytes from a receive port that holds a byte while a valid flag is high, and it pops that byte when software reads the data slot. It builds the line status from live engine state and a sticky reset value, and it raises transmit and receive interrupt requests under control of the interrupt-enable bits. The baud generator, the shifters and any FIFOs are outside the block.

Top module: `uart_rf_top`

## Requirements
- R1: After reset, divisor low reads 0x0001, the identification slot reads 0x0001 and the sticky line-status value is 0x0060. All other storage is zero, and txValid, txIrq, rxIrq, busErr and busRdata are 0.
- R2: Slots decode on byte offsets as follows: data 0x00, interrupt enable 0x04, identification 0x08, line control 0x0C, modem control 0x10, line status 0x14, modem status 0x18, scratch 0x1C, reserved 0x20, global control 0x24.
- R3: While line-control bit 7 is 1, offset 0x00 reads and writes divisor low and offset 0x04 reads and writes divisor high. Such a write causes no transmit.
- R4: While line-control bit 7 is 0, a write to 0x00 loads bits 7:0 of the data into txData and sets txValid on the next edge. txValid stays 1 until an edge where txReady is 1.
- R5: While line-control bit 7 is 0, a read of 0x00 returns rxData zero-extended. rxPop is high in the same cycle as the read strobe when rxValid is 1, and low otherwise.
- R6: Interrupt enable, line control, modem control, scratch and global control store all 16 bits. Writes to identification, line status and modem status are dropped. Modem status reads 0.
- R7: A line-status read returns the sticky value OR'd with the live bits and then clears the sticky value. The live bits are bit 0 = rxValid, bit 5 = no transmit byte pending, and bit 6 = bit 5 and txIdle.
- R8: txIrq pulses for one cycle, on the edge after a transmit-data write, only if interrupt-enable bit 1 was 1 at that write.
- R9: rxIrq is registered from rxValid AND interrupt-enable bit 0.
- R10: An access that is not 16 bits wide (busWide = 0), not 4-byte aligned, to the reserved slot, or beyond 0x24 raises busErr for one cycle. It returns zero read data and changes no state.
- R11: Read data appears on the edge after the read strobe and holds until the next read or error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 6 | Byte offset of the access |
| busWrite | input | 1 | Write strobe |
| busRead | input | 1 | Read strobe |
| busWide | input | 1 | High for a 16-bit access |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Registered read data |
| busErr | output | 1 | One-cycle access error pulse |
| txData | output | 8 | Byte offered to the serializer |
| txValid | output | 1 | Transmit byte pending |
| txReady | input | 1 | Serializer takes the byte |
| txIdle | input | 1 | Serializer shift register empty |
| rxData | input | 8 | Received byte |
| rxValid | input | 1 | Received byte available |
| rxPop | output | 1 | Consume the received byte |
| txIrq | output | 1 | Transmit interrupt request |
| rxIrq | output | 1 | Receive interrupt request |

## Verification
The bench drives accesses to every slot with the latch bit both clear and set. This separates divisor aliasing from data and enable traffic and shows that a divisor write never starts a transmit. Repeated status reads with txIdle and rxValid held at different levels separate the sticky reset bits from the live bits. Transmit writes with the serializer stalled, and then with it ready, separate holding from acceptance, while writes with the enable bits set and cleared show interrupt gating. Misaligned, narrow, reserved and out-of-range accesses, each followed by a legal read-back, show that errors leave state untouched.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

  // Slot numbers (byte offset / 4); the order is decoded by software.
  localparam int SLOT_DATA = 0;
  localparam int SLOT_IER  = 1;
  localparam int SLOT_IIR  = 2;
  localparam int SLOT_LCR  = 3;
  localparam int SLOT_MCR  = 4;
  localparam int SLOT_LSR  = 5;
  localparam int SLOT_MSR  = 6;
  localparam int SLOT_SCR  = 7;
  localparam int SLOT_GCTL = 9;

  localparam int LATCH_BIT   = 7;  // line control: divisor access
  localparam int IE_RX_BIT   = 0;
  localparam int IE_TX_BIT   = 1;
  localparam int ST_READY    = 0;
  localparam int ST_HOLD_EMP = 5;
  localparam int ST_SHFT_EMP = 6;

  typedef enum logic [3:0] {
    SEL_ZERO, SEL_RBR, SEL_DLL, SEL_DLH, SEL_IER, SEL_IIR,
    SEL_LCR, SEL_MCR, SEL_LSR, SEL_SCR, SEL_GCTL
  } rdSel_e;

  typedef struct packed {
    logic   wrThr;
    logic   wrDll;
    logic   wrDlh;
    logic   wrIer;
    logic   wrLcr;
    logic   wrMcr;
    logic   wrScr;
    logic   wrGctl;
    logic   rdEn;
    logic   rdLsr;
    logic   err;
    rdSel_e rdSel;
  } rfStrobes_t;

endpackage

// File: rtl/uart_rf_ctrl.sv
module uart_rf_ctrl
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic              busWide,
  input  logic              latchOn,
  input  logic              rxValid,
  output rfStrobes_t        strobes,
  output logic              rxPop
);

  localparam int SLOT_W = ADDR_W - 2;

  logic [SLOT_W-1:0] slot;
  logic access, known, bad, wr, rd;

  assign slot   = busAddr[ADDR_W-1:2];
  assign access = busWrite | busRead;

  always_comb begin
    case (int'(slot))
      SLOT_DATA, SLOT_IER, SLOT_IIR, SLOT_LCR, SLOT_MCR,
      SLOT_LSR, SLOT_MSR, SLOT_SCR, SLOT_GCTL: known = 1'b1;
      default: known = 1'b0;
    endcase
  end

  assign bad = access && (!busWide || (busAddr[1:0] != 2'b00) || !known);
  assign wr  = busWrite && !bad;
  assign rd  = busRead && !bad;

  always_comb begin
    strobes       = '0;
    strobes.rdSel = SEL_ZERO;
    strobes.err   = bad;
    strobes.rdEn  = rd;
    case (int'(slot))
      SLOT_DATA: begin
        if (latchOn) begin
          strobes.wrDll = wr;
          strobes.rdSel = SEL_DLL;
        end else begin
          strobes.wrThr = wr;
          strobes.rdSel = SEL_RBR;
        end
      end
      SLOT_IER: begin
        if (latchOn) begin
          strobes.wrDlh = wr;
          strobes.rdSel = SEL_DLH;
        end else begin
          strobes.wrIer = wr;
          strobes.rdSel = SEL_IER;
        end
      end
      SLOT_IIR:  strobes.rdSel = SEL_IIR;
      SLOT_LCR: begin
        strobes.wrLcr = wr;
        strobes.rdSel = SEL_LCR;
      end
      SLOT_MCR: begin
        strobes.wrMcr = wr;
        strobes.rdSel = SEL_MCR;
      end
      SLOT_LSR: begin
        strobes.rdLsr = rd;
        strobes.rdSel = SEL_LSR;
      end
      SLOT_SCR: begin
        strobes.wrScr = wr;
        strobes.rdSel = SEL_SCR;
      end
      SLOT_GCTL: begin
        strobes.wrGctl = wr;
        strobes.rdSel  = SEL_GCTL;
      end
      default: strobes.rdSel = SEL_ZERO;
    endcase
  end

  assign rxPop = rd && !latchOn && (int'(slot) == SLOT_DATA) && rxValid;

endmodule

// File: rtl/uart_rf_dpath.sv
module uart_rf_dpath
  import uart_rf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rfStrobes_t        strobes,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              rxValid,
  input  logic              txReady,
  input  logic              txIdle,
  output logic [DATA_W-1:0] busRdata,
  output logic              busErr,
  output logic [BYTE_W-1:0] txData,
  output logic              txValid,
  output logic              txIrq,
  output logic              rxIrq,
  output logic              latchOn
);

  localparam logic [DATA_W-1:0] DLL_RST  = DATA_W'(1);
  localparam logic [DATA_W-1:0] IIR_IDLE = DATA_W'(1);
  localparam logic [DATA_W-1:0] LSR_RST  =
    (DATA_W'(1) << ST_HOLD_EMP) | (DATA_W'(1) << ST_SHFT_EMP);

  logic [DATA_W-1:0] dllQ, dlhQ, ierQ, lcrQ, mcrQ, scrQ, gctlQ, stickyQ;
  logic [DATA_W-1:0] liveSt, rdMux, rdataQ;
  logic [BYTE_W-1:0] txDataQ;
  logic txValidQ, txIrqQ, rxIrqQ, errQ;

  assign latchOn = lcrQ[LATCH_BIT];

  always_comb begin
    liveSt              = '0;
    liveSt[ST_READY]    = rxValid;
    liveSt[ST_HOLD_EMP] = !txValidQ;
    liveSt[ST_SHFT_EMP] = !txValidQ && txIdle;
  end

  always_comb begin
    case (strobes.rdSel)
      SEL_RBR:  rdMux = DATA_W'(rxData);
      SEL_DLL:  rdMux = dllQ;
      SEL_DLH:  rdMux = dlhQ;
      SEL_IER:  rdMux = ierQ;
      SEL_IIR:  rdMux = IIR_IDLE;
      SEL_LCR:  rdMux = lcrQ;
      SEL_MCR:  rdMux = mcrQ;
      SEL_LSR:  rdMux = stickyQ | liveSt;
      SEL_SCR:  rdMux = scrQ;
      SEL_GCTL: rdMux = gctlQ;
      default:  rdMux = '0;
    endcase
  end

  // Control storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dllQ  <= DLL_RST;
      dlhQ  <= '0;
      ierQ  <= '0;
      lcrQ  <= '0;
      mcrQ  <= '0;
      scrQ  <= '0;
      gctlQ <= '0;
    end else begin
      if (strobes.wrDll)  dllQ  <= busWdata;
      if (strobes.wrDlh)  dlhQ  <= busWdata;
      if (strobes.wrIer)  ierQ  <= busWdata;
      if (strobes.wrLcr)  lcrQ  <= busWdata;
      if (strobes.wrMcr)  mcrQ  <= busWdata;
      if (strobes.wrScr)  scrQ  <= busWdata;
      if (strobes.wrGctl) gctlQ <= busWdata;
    end
  end

  // Read return and status
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdataQ  <= '0;
      errQ    <= 1'b0;
      stickyQ <= LSR_RST;
    end else begin
      errQ <= strobes.err;
      if (strobes.err)       rdataQ <= '0;
      else if (strobes.rdEn) rdataQ <= rdMux;
      if (strobes.rdLsr)     stickyQ <= '0;
    end
  end

  // Transmit handoff and interrupt requests
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txDataQ  <= '0;
      txValidQ <= 1'b0;
      txIrqQ   <= 1'b0;
      rxIrqQ   <= 1'b0;
    end else begin
      if (strobes.wrThr) begin
        txDataQ  <= busWdata[BYTE_W-1:0];
        txValidQ <= 1'b1;
      end else if (txValidQ && txReady) begin
        txValidQ <= 1'b0;
      end
      txIrqQ <= strobes.wrThr && ierQ[IE_TX_BIT];
      rxIrqQ <= rxValid && ierQ[IE_RX_BIT];
    end
  end

  assign busRdata = rdataQ;
  assign busErr   = errQ;
  assign txData   = txDataQ;
  assign txValid  = txValidQ;
  assign txIrq    = txIrqQ;
  assign rxIrq    = rxIrqQ;

endmodule

// File: rtl/uart_rf_top.sv
module uart_rf_top
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic              busWide,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busErr,
  output logic [BYTE_W-1:0] txData,
  output logic              txValid,
  input  logic              txReady,
  input  logic              txIdle,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              rxValid,
  output logic              rxPop,
  output logic              txIrq,
  output logic              rxIrq
);

  rfStrobes_t strobes;
  logic latchOn;

  uart_rf_ctrl #(.ADDR_W(ADDR_W)) ctrl (
    .busAddr (busAddr),
    .busWrite(busWrite),
    .busRead (busRead),
    .busWide (busWide),
    .latchOn (latchOn),
    .rxValid (rxValid),
    .strobes (strobes),
    .rxPop   (rxPop)
  );

  uart_rf_dpath #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .busWdata(busWdata),
    .rxData  (rxData),
    .rxValid (rxValid),
    .txReady (txReady),
    .txIdle  (txIdle),
    .busRdata(busRdata),
    .busErr  (busErr),
    .txData  (txData),
    .txValid (txValid),
    .txIrq   (txIrq),
    .rxIrq   (rxIrq),
    .latchOn (latchOn)
  );

endmodule

// File: rtl/uart_rf_chk.sv
module uart_rf_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] busRdata,
  input logic              busErr,
  input logic              txValid,
  input logic              txReady,
  input logic              txIrq,
  input logic              rxValid,
  input logic              rxPop,
  input logic              rxIrq
);

  // R8
  tx_irq_with_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> txValid);

  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> txValid);

  // R5
  pop_needs_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxPop |-> rxValid);

  // R10
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> (busRdata == '0));

  // R9
  rx_irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> $past(rxValid));

endmodule

bind uart_rf_top uart_rf_chk #(.DATA_W(DATA_W)) chk (
  .clk     (clk),
  .rstN    (rstN),
  .busRdata(busRdata),
  .busErr  (busErr),
  .txValid (txValid),
  .txReady (txReady),
  .txIrq   (txIrq),
  .rxValid (rxValid),
  .rxPop   (rxPop),
  .rxIrq   (rxIrq)
);

// File: tb/uart_rf_top_test.sv
module uart_rf_top_test;

  logic clk = 1'b0;
  logic rstN;
  logic [5:0] bAddr;
  logic bWr, bRd, bWide;
  logic [15:0] bWdata;
  logic [15:0] busRdata;
  logic busErr, txValid, rxPop, txIrq, rxIrq;
  logic [7:0] txData, rxData;
  logic txReady, txIdle, rxValid;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;
  string tag  = "R1";

  // Reference state
  logic [15:0] mDll, mDlh, mIer, mLcr, mMcr, mScr, mGctl, mSticky;
  logic [15:0] eRdata;
  logic [7:0]  eTxData;
  logic eErr, eTxV, eTxIrq, eRxIrq;

  always #10 clk = ~clk;

  uart_rf_top uut (
    .clk(clk), .rstN(rstN), .busAddr(bAddr), .busWrite(bWr), .busRead(bRd),
    .busWide(bWide), .busWdata(bWdata), .busRdata(busRdata), .busErr(busErr),
    .txData(txData), .txValid(txValid), .txReady(txReady), .txIdle(txIdle),
    .rxData(rxData), .rxValid(rxValid), .rxPop(rxPop), .txIrq(txIrq), .rxIrq(rxIrq)
  );

  task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("busRdata", busRdata, eRdata);
    chk("busErr", 16'(busErr), 16'(eErr));
    chk("txValid", 16'(txValid), 16'(eTxV));
    if (eTxV) chk("txData", 16'(txData), 16'(eTxData));
    chk("txIrq", 16'(txIrq), 16'(eTxIrq));
    chk("rxIrq", 16'(rxIrq), 16'(eRxIrq));
  endtask

  function automatic void modelReset();
    mDll = 16'h0001; mDlh = 0; mIer = 0; mLcr = 0; mMcr = 0; mScr = 0;
    mGctl = 0; mSticky = 16'h0060;
    eRdata = 0; eTxData = 0; eErr = 0; eTxV = 0; eTxIrq = 0; eRxIrq = 0;
  endfunction

  // One bus cycle with the inputs already driven
  task automatic step();
    int off;
    bit acc, bad, dl, okRd, okWr, popExp, nTxV;
    logic [15:0] v, live;
    #1;
    off  = int'(bAddr);
    acc  = bWr || bRd;
    bad  = acc && (!bWide || (off % 4) != 0 || off == 32 || off > 36);
    okRd = bRd && !bad;
    okWr = bWr && !bad;
    dl   = mLcr[7];
    popExp = okRd && off == 0 && !dl && rxValid;
    chk("rxPop", 16'(rxPop), 16'(popExp));
    live = 0;
    live[0] = rxValid;
    live[5] = !eTxV;
    live[6] = !eTxV && txIdle;
    v = 0;
    if (off == 0)       v = dl ? mDll : {8'h00, rxData};
    else if (off == 4)  v = dl ? mDlh : mIer;
    else if (off == 8)  v = 16'h0001;
    else if (off == 12) v = mLcr;
    else if (off == 16) v = mMcr;
    else if (off == 20) v = mSticky | live;
    else if (off == 28) v = mScr;
    else if (off == 36) v = mGctl;
    eTxIrq = okWr && off == 0 && !dl && mIer[1];
    eRxIrq = rxValid && mIer[0];
    nTxV = eTxV;
    if (eTxV && txReady) nTxV = 0;
    if (okWr && off == 0 && !dl) begin nTxV = 1; eTxData = bWdata[7:0]; end
    eTxV = nTxV;
    eErr = bad;
    if (bad) eRdata = 0;
    else if (okRd) eRdata = v;
    if (okRd && off == 20) mSticky = 0;
    if (okWr) begin
      if (off == 0 && dl)       mDll = bWdata;
      else if (off == 4 && dl)  mDlh = bWdata;
      else if (off == 4)        mIer = bWdata;
      else if (off == 12)       mLcr = bWdata;
      else if (off == 16)       mMcr = bWdata;
      else if (off == 28)       mScr = bWdata;
      else if (off == 36)       mGctl = bWdata;
    end
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle();
    bWr = 0; bRd = 0; bWide = 1; bAddr = 0; bWdata = 0;
    step();
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d, input bit wide = 1);
    bWr = 1; bRd = 0; bWide = wide; bAddr = a; bWdata = d;
    step();
    bWr = 0;
  endtask

  task automatic rd(input logic [5:0] a, input bit wide = 1);
    bWr = 0; bRd = 1; bWide = wide; bAddr = a; bWdata = 0;
    step();
    bRd = 0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 0; bWr = 0; bRd = 0; bWide = 1; bAddr = 0; bWdata = 0;
    rxData = 0; rxValid = 0; txReady = 0; txIdle = 1;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    tag = "R1"; compareAll();
    rd(6'h08);                       // R1 identification reset value
    txIdle = 0;
    tag = "R7"; rd(6'h14);           // sticky 0x60 visible
    rd(6'h14);                       // sticky cleared, live only
    txIdle = 1; rd(6'h14);
    tag = "R11"; idle(); idle();     // read data held

    tag = "R3"; wr(6'h0C, 16'h0080);
    rd(6'h00); wr(6'h00, 16'h1234); wr(6'h04, 16'hABCD);
    rd(6'h00); rd(6'h04); idle();
    wr(6'h0C, 16'h0003);

    tag = "R6";
    wr(6'h04, 16'h0003); rd(6'h04);
    wr(6'h10, 16'hBEEF); wr(6'h1C, 16'h5A5A); wr(6'h24, 16'hC3C3);
    rd(6'h10); rd(6'h1C); rd(6'h24);
    wr(6'h08, 16'hFFFF); wr(6'h14, 16'hFFFF); wr(6'h18, 16'hFFFF);
    rd(6'h08); rd(6'h18); rd(6'h14);
    tag = "R2"; rd(6'h0C); rd(6'h00); rd(6'h04);

    tag = "R4"; txReady = 0;
    wr(6'h00, 16'h01A5);            // R8 irq expected, IER bit1 set
    tag = "R8"; idle(); idle();
    tag = "R7"; txIdle = 0; rd(6'h14);
    tag = "R4"; txReady = 1; idle(); txReady = 0; idle();
    tag = "R8"; wr(6'h04, 16'h0001);
    wr(6'h00, 16'h0077); txReady = 1; idle(); idle();
    wr(6'h00, 16'h0011); wr(6'h00, 16'h0022); idle();
    txReady = 0; txIdle = 1;

    tag = "R5"; rxData = 8'h5C; rxValid = 1;
    idle(); rd(6'h00);
    tag = "R9"; idle(); wr(6'h04, 16'h0002); idle(); idle();
    rxValid = 0; rd(6'h00); idle();
    tag = "R7"; rxValid = 1; rd(6'h14); rxValid = 0;
    tag = "R5"; wr(6'h0C, 16'h0080); rxValid = 1; rd(6'h00);
    rxValid = 0; wr(6'h0C, 16'h0000);

    tag = "R10";
    rd(6'h20); rd(6'h28); rd(6'h3C); rd(6'h02); rd(6'h24, 0);
    wr(6'h24, 16'h1111, 0); wr(6'h22, 16'h2222); wr(6'h00, 16'h0099, 0);
    rd(6'h24); idle(); rd(6'h1C); wr(6'h20, 16'hFFFF); rd(6'h0C);
    tag = "R11"; idle(); idle();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule